// File: doc/BRIEF.md
# N-Line Polarity Inversion Generator

This block produces the drive polarity bit for a multiplexed LCD. The polarity flips after a programmable number of scanned lines, which spreads the AC drive over short groups of lines and reduces crosstalk between rows. Two strobes drive it: one for each scanned line and one for the start of each frame. The frame and line timing come from outside the block.

A 6-bit interval code sets the number of lines between polarity flips. Code 0 turns line-based inversion off, and the polarity then flips once per frame. Codes 1 to 63 give an interval of code + 1 lines (2 to 64). A free-run flag selects whether the line count restarts at each frame or runs on across frame boundaries. The block accepts a new configuration only at a frame start, so no interval is cut short in the middle of a frame.

Top module: `nlinv_top`

## Requirements
- R1: After reset the polarity is 0, the line count is 0, and the active interval code is 16 (17 lines). The 17-line interval is in use before any frame start.
- R2: With an active code c from 1 to 63, the polarity inverts on every (c+1)-th accepted line strobe and on no other line strobe.
- R3: With code 0 at a frame start, that frame start inverts the polarity. While code 0 is active, line strobes never change the polarity.
- R4: A frame start that loads a nonzero code leaves the polarity unchanged.
- R5: A frame start with the free-run flag at 0 restarts the line count, so the first inversion comes after c+1 line strobes of the new frame.
- R6: A frame start with the free-run flag at 1 keeps the line count, so the interval carries across the frame boundary.
- R7: The interval code and the free-run flag are sampled only at a frame start. A change between frame starts has no effect until the next one.
- R8: When a frame start and a line strobe arrive in the same cycle, the line strobe is ignored.
- R9: In free-run mode, if the count held at a frame start is larger than the newly loaded code, the count restarts at 0.
- R10: The polarity output is registered. It changes on the clock edge that samples the strobe and holds through the cycle in which the strobe is driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_adv | input | 1 | One-cycle strobe for each scanned line |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| cfg_code | input | CODE_W (6) | Interval code: 0 turns line inversion off, c from 1 to 63 gives c+1 lines |
| cfg_free_run | input | 1 | 1 keeps the line count across frames, 0 restarts it at each frame |
| polarity | output | 1 | Drive polarity |

## Verification
The bound checker tests the following on every cycle:
- Idle cycles leave the polarity unchanged.
- A frame start that loads a nonzero code leaves the polarity unchanged.
- A frame start that loads code 0 inverts the polarity.
- While inversion is off, line strobes have no effect.
- The active code moves only at a frame start.
- The line count stays within the active interval.
- Reaching the last line of an interval inverts the polarity on the next cycle.

Some behaviour depends on sequences of strobes and is shown only by the bench scenarios:
- The exact interval length at the smallest, the reset and the largest code.
- Whether the count restarts or carries across frames.
- That a mid-frame configuration change is deferred.
- That a line strobe arriving together with a frame start is dropped.
- The count restart when a smaller code is loaded in free-run mode.

// File: rtl/nlinv_pkg.sv
// Package nlinv_pkg
// Types and defaults shared by the N-line polarity inversion generator.
// Assumes a 6-bit interval code unless a parent overrides the width.
package nlinv_pkg;

    // Width of the interval code
    parameter int NLI_CODE_W    = 6;
    // Interval code loaded by reset (17 lines)
    parameter int NLI_RST_CODE  = 16;

    // Strobe event seen in one cycle; the frame strobe has priority
    typedef enum logic [1:0] {
        EV_IDLE  = 2'd0,
        EV_FRAME = 2'd1,
        EV_LINE  = 2'd2
    } nli_event_t;

    // Classify the two strobes into a single event
    function automatic nli_event_t nli_classify(input logic frame_s, input logic line_s);
        if (frame_s)     return EV_FRAME;
        else if (line_s) return EV_LINE;
        else             return EV_IDLE;
    endfunction

endpackage

// File: rtl/nlinv_cfg_shadow.sv
// Module nlinv_cfg_shadow
// Holds the active interval code. It loads the incoming code only on a
// frame event and holds it for the rest of the frame.
// Assumes: reset is synchronous and active low.
module nlinv_cfg_shadow #(
    parameter int CODE_W   = 6,
    parameter int RST_CODE = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  nlinv_pkg::nli_event_t  ev,
    input  logic [CODE_W-1:0]      new_code,
    output logic [CODE_W-1:0]      act_code
);
    import nlinv_pkg::*;

    localparam logic [CODE_W-1:0] RST_VAL = CODE_W'(RST_CODE);

    // Load the code at a frame event, otherwise hold it
    always_ff @(posedge clk) begin
        if (!rst_n)              act_code <= RST_VAL;
        else if (ev == EV_FRAME) act_code <= new_code;
    end

endmodule

// File: rtl/nlinv_line_counter.sv
// Module nlinv_line_counter
// Counts the line strobes accepted since the last polarity inversion and
// flags the strobe that closes an interval of act_code+1 lines.
// At a frame event the count restarts unless free-run is requested and the
// count still fits within the new code.
// Assumes: line events are ignored while the active code is 0.
module nlinv_line_counter #(
    parameter int CODE_W = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  nlinv_pkg::nli_event_t  ev,
    input  logic [CODE_W-1:0]      act_code,
    input  logic [CODE_W-1:0]      new_code,
    input  logic                   new_free_run,
    output logic [CODE_W-1:0]      cnt,
    output logic                   line_wrap
);
    import nlinv_pkg::*;

    logic act_on;
    logic keep_on_frame;

    // Line inversion is on while the active code is nonzero
    assign act_on        = (act_code != '0);
    // At a frame event, keep the count only in free-run mode when it fits the new code
    assign keep_on_frame = new_free_run && (new_code != '0) && (cnt <= new_code);

    // Flag the line strobe that closes the current interval
    always_comb begin
        line_wrap = (ev == EV_LINE) && act_on && (cnt == act_code);
    end

    // Advance, wrap, restart or hold the line count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            case (ev)
                EV_FRAME: if (!keep_on_frame) cnt <= '0;
                EV_LINE: begin
                    if (line_wrap)   cnt <= '0;
                    else if (act_on) cnt <= cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nlinv_pol_reg.sv
// Module nlinv_pol_reg
// Holds the drive polarity. It inverts when a line interval closes, or at a
// frame event that selects frame inversion (code 0).
// Assumes: the two inversion causes never occur in the same cycle.
module nlinv_pol_reg (
    input  logic                   clk,
    input  logic                   rst_n,
    input  nlinv_pkg::nli_event_t  ev,
    input  logic                   line_wrap,
    input  logic                   new_code_zero,
    output logic                   polarity
);
    import nlinv_pkg::*;

    logic flip;

    // Collect the two inversion causes
    assign flip = line_wrap || ((ev == EV_FRAME) && new_code_zero);

    // Invert the polarity when either cause is present
    always_ff @(posedge clk) begin
        if (!rst_n)    polarity <= 1'b0;
        else if (flip) polarity <= ~polarity;
    end

endmodule

// File: rtl/nlinv_top.sv
// Module nlinv_top
// N-line polarity inversion generator. It turns line and frame strobes into
// an LCD drive polarity bit that inverts every code+1 lines, or once per
// frame when the code is 0.
// Assumes: both strobes are synchronous to clk and one cycle wide.
module nlinv_top #(
    parameter int CODE_W   = nlinv_pkg::NLI_CODE_W,
    parameter int RST_CODE = nlinv_pkg::NLI_RST_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_adv,
    input  logic              frame_start,
    input  logic [CODE_W-1:0] cfg_code,
    input  logic              cfg_free_run,
    output logic              polarity
);
    import nlinv_pkg::*;

    nli_event_t        ev;
    logic [CODE_W-1:0] act_code;
    logic [CODE_W-1:0] line_cnt;
    logic              line_wrap;
    logic              new_code_zero;

    // Merge the strobes into one event; the frame strobe wins
    assign ev            = nli_classify(frame_start, line_adv);
    assign new_code_zero = (cfg_code == '0);

    nlinv_cfg_shadow #(
        .CODE_W   (CODE_W),
        .RST_CODE (RST_CODE)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev),
        .new_code (cfg_code),
        .act_code (act_code)
    );

    nlinv_line_counter #(
        .CODE_W (CODE_W)
    ) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .act_code     (act_code),
        .new_code     (cfg_code),
        .new_free_run (cfg_free_run),
        .cnt          (line_cnt),
        .line_wrap    (line_wrap)
    );

    nlinv_pol_reg u_pol (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev            (ev),
        .line_wrap     (line_wrap),
        .new_code_zero (new_code_zero),
        .polarity      (polarity)
    );

endmodule

// File: rtl/nlinv_checker.sv
// Module nlinv_checker
// Cycle-level properties of the inversion generator. It is bound to
// nlinv_top and observes the ports together with the active code and the
// line count.
module nlinv_checker #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_adv,
    input logic              frame_start,
    input logic [CODE_W-1:0] cfg_code,
    input logic [CODE_W-1:0] act_code,
    input logic [CODE_W-1:0] line_cnt,
    input logic              polarity
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !line_adv) |=> $stable(polarity));                     // R10

    AST_FRAME_NLINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cfg_code != '0) |=> $stable(polarity));                 // R4

    AST_FRAME_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cfg_code == '0) |=> (polarity != $past(polarity)));     // R3

    AST_OFF_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && line_adv && act_code == '0) |=> $stable(polarity));    // R3

    AST_CFG_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start) |=> $stable(act_code));                                  // R7

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_cnt <= act_code) || (act_code == '0 && line_cnt == '0));          // R9

    AST_INTERVAL_END: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && line_adv && act_code != '0 && line_cnt == act_code)
        |=> (polarity != $past(polarity)));                                     // R2

endmodule

bind nlinv_top nlinv_checker #(.CODE_W(CODE_W)) u_nlinv_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_adv    (line_adv),
    .frame_start (frame_start),
    .cfg_code    (cfg_code),
    .act_code    (act_code),
    .line_cnt    (line_cnt),
    .polarity    (polarity)
);

// File: tb/nlinv_top_bench.sv
`timescale 1ns/1ps
module nlinv_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_adv = 1'b0;
    logic       frame_start = 1'b0;
    logic [5:0] cfg_code = 6'd16;
    logic       cfg_free_run = 1'b0;
    logic       polarity;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nlinv_top u_nlinv_top (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_adv     (line_adv),
        .frame_start  (frame_start),
        .cfg_code     (cfg_code),
        .cfg_free_run (cfg_free_run),
        .polarity     (polarity)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s polarity actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One line strobe; returns at the negedge after the sampling edge
    task automatic line_pulse();
        @(negedge clk) line_adv = 1'b1;
        @(negedge clk) line_adv = 1'b0;
    endtask

    task automatic lines(input int n);
        for (int i = 0; i < n; i++) line_pulse();
    endtask

    task automatic frame_pulse();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
    endtask

    // Load a configuration and apply it with a count-restarting frame start
    task automatic fresh_frame(input logic [5:0] code);
        cfg_code = code; cfg_free_run = 1'b0;
        frame_pulse();
    endtask

    task automatic t_reset();
        logic p0;
        @(negedge clk);
        chk("R1 reset polarity", polarity, 1'b0);
        p0 = polarity;
        lines(16);
        chk("R1 default 17-line interval, 16 lines", polarity, p0);
        line_pulse();
        chk("R1 default 17-line interval, 17th line", polarity, ~p0);
    endtask

    task automatic t_interval(input logic [5:0] code);
        logic p0;
        fresh_frame(code);
        p0 = polarity;
        lines(int'(code));
        chk("R2 no inversion before interval end", polarity, p0);
        @(negedge clk) line_adv = 1'b1;
        #5 chk("R10 polarity holds before sampling edge", polarity, p0);
        @(negedge clk) line_adv = 1'b0;
        chk("R2 inversion at interval end", polarity, ~p0);
        lines(int'(code));
        chk("R2 second interval early", polarity, ~p0);
        line_pulse();
        chk("R2 second interval end", polarity, p0);
    endtask

    task automatic t_disabled();
        logic p0;
        p0 = polarity;
        fresh_frame(6'd0);
        chk("R3 frame inversion at frame start", polarity, ~p0);
        lines(100);
        chk("R3 line strobes ignored when off", polarity, ~p0);
        frame_pulse();
        chk("R3 second frame inversion", polarity, p0);
    endtask

    task automatic t_frame_hold();
        logic p0;
        p0 = polarity;
        fresh_frame(6'd3);
        chk("R4 frame start with nonzero code holds", polarity, p0);
        frame_pulse();
        chk("R4 repeated frame start holds", polarity, p0);
    endtask

    task automatic t_restart();
        logic p0;
        fresh_frame(6'd4);
        p0 = polarity;
        lines(3);
        frame_pulse();
        lines(4);
        chk("R5 count restarted, 4 lines into frame", polarity, p0);
        line_pulse();
        chk("R5 count restarted, 5th line inverts", polarity, ~p0);
    endtask

    task automatic t_free_run();
        logic p0;
        fresh_frame(6'd4);
        p0 = polarity;
        cfg_free_run = 1'b1;
        lines(3);
        frame_pulse();
        line_pulse();
        chk("R6 count carried, 4th line", polarity, p0);
        line_pulse();
        chk("R6 count carried, 5th line inverts", polarity, ~p0);
        cfg_free_run = 1'b0;
    endtask

    task automatic t_defer();
        logic p0;
        fresh_frame(6'd2);
        p0 = polarity;
        cfg_code = 6'd10;
        cfg_free_run = 1'b1;
        lines(3);
        chk("R7 mid-frame code change deferred", polarity, ~p0);
        lines(2);
        chk("R7 old interval still in force", polarity, ~p0);
        cfg_free_run = 1'b0;
        frame_pulse();
        lines(10);
        chk("R7 new code after frame, 10 lines", polarity, ~p0);
        line_pulse();
        chk("R7 new code after frame, 11th line", polarity, p0);
    endtask

    task automatic t_simultaneous();
        logic p0;
        fresh_frame(6'd1);
        p0 = polarity;
        line_pulse();
        @(negedge clk) begin frame_start = 1'b1; line_adv = 1'b1; end
        @(negedge clk) begin frame_start = 1'b0; line_adv = 1'b0; end
        chk("R8 line strobe with frame start ignored", polarity, p0);
        line_pulse();
        chk("R8 count restarted, 1 line", polarity, p0);
        line_pulse();
        chk("R8 count restarted, 2nd line inverts", polarity, ~p0);
    endtask

    task automatic t_clamp();
        logic p0;
        fresh_frame(6'd10);
        p0 = polarity;
        lines(8);
        cfg_code = 6'd3;
        cfg_free_run = 1'b1;
        frame_pulse();
        lines(3);
        chk("R9 oversized count restarted, 3 lines", polarity, p0);
        line_pulse();
        chk("R9 oversized count restarted, 4th line", polarity, ~p0);
        cfg_free_run = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_interval(6'd1);
        t_interval(6'd5);
        t_interval(6'd63);
        t_disabled();
        t_frame_hold();
        t_restart();
        t_free_run();
        t_defer();
        t_simultaneous();
        t_clamp();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule